// File: doc/BRIEF.md
# Back-to-back butterfly permutation network

The block rearranges N = 2^n data lanes into any order. Its fabric is a forward butterfly followed by a mirrored butterfly. The stage where the two halves meet is shared, so the fabric has 2n−1 stages of N two-input multiplexers. Each multiplexer either keeps its own lane from the previous stage or takes the lane of its partner. Given a conflict-free set of select bits, the fabric can produce every one of the N! lane orders.

Select bits are not computed on chip. A small control store holds ENTRIES precomputed select patterns, and a write port loads them. A permutation identifier, sampled with the data, picks the active pattern.

A pattern may treat disjoint lane ranges as separate frames, each with its own rearrangement. Data and identifier are registered on the same edge. The permuted result therefore appears one clock after the inputs are sampled, and the delay through the fabric is 2n−1 multiplexers.

Top module: `b2b_perm_net`

## Requirements
- R1: While reset is asserted, and after its release until the first rising edge, data_o is all zeros. Reset leaves every control entry at the all-zero (identity) pattern.
- R2: data_o is the rearrangement of data_i by the entry named by perm_id_i, both sampled at the previous rising edge. data_o does not change between rising edges.
- R3: Stage s (s = 0 .. 2n−2) has partner distance d = N/2^(s+1) for s < n and d = 2^(s−n+1) otherwise. Multiplexer j of stage s takes lane j of the previous stage on select 0 and lane j XOR d on select 1. Stage 0 takes data lanes, and the last stage drives data_o. Lane k is bits [k*WIDTH +: WIDTH] of the data buses.
- R4: Bit s*N + j of a control entry is the select of multiplexer j in stage s.
- R5: An all-zero entry passes every lane straight through.
- R6: With N = 4, entry 12'hA35 gives z3=x2, z2=x0, z1=x3, z0=x1. Entry 12'hFFA gives z_j = x_((j+1) mod 4), and entry 12'h00F gives z_j = x_(j XOR 2).
- R7: When wr_en_i is high at a rising edge, wr_data_i is stored into entry wr_addr_i. A read at the same edge of the same entry returns its previous contents. A read at any later edge returns the new contents.
- R8: A write changes only the addressed entry.
- R9: A pattern may act on disjoint lane ranges as independent frames. With N = 4, entry 12'h030 swaps lanes 0 and 1 and leaves lanes 2 and 3 in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | N*WIDTH | Input lanes, lane k at [k*WIDTH +: WIDTH] |
| perm_id_i | input | log2(ENTRIES) | Control entry applied to this data |
| wr_en_i | input | 1 | Control store write enable |
| wr_addr_i | input | log2(ENTRIES) | Control store write address |
| wr_data_i | input | N*(2n−1) | Select pattern to store |
| data_o | output | N*WIDTH | Permuted lanes |

## Verification
A permuted result is due one rising edge after data_i and perm_id_i are sampled. A stored pattern can be read at the edge after the one that writes it, so it reaches data_o one clock later still. The bench changes inputs on the falling edge and compares data_o at the next falling edge. It also checks, just after new inputs are applied, that data_o still holds the previous result. The same-edge write-and-read case is checked twice: the old pattern must appear first, and the new pattern one cycle later.

// File: rtl/b2b_perm_pkg.sv
package b2b_perm_pkg;

  // partner distance of stage s in a network of 2^log2n lanes
  function automatic int stage_dist(input int log2n, input int s);
    if (s < log2n) return 1 << (log2n - 1 - s);
    else           return 1 << (s - log2n + 1);
  endfunction

endpackage

// File: rtl/b2b_perm_stage.sv
module b2b_perm_stage #(
  parameter int LANES = 8,
  parameter int WIDTH = 8,
  parameter int DIST  = 4
) (
  input  logic [LANES*WIDTH-1:0] lanes_i,
  input  logic [LANES-1:0]       sel_i,
  output logic [LANES*WIDTH-1:0] lanes_o
);

  for (genvar j = 0; j < LANES; j++) begin : g_mux
    localparam int PARTNER = j ^ DIST;
    assign lanes_o[j*WIDTH +: WIDTH] = sel_i[j] ? lanes_i[PARTNER*WIDTH +: WIDTH]
                                                : lanes_i[j*WIDTH +: WIDTH];
  end

endmodule

// File: rtl/b2b_perm_fabric.sv
module b2b_perm_fabric #(
  parameter int LANES_LOG2 = 3,
  parameter int WIDTH      = 8,
  localparam int LANES     = 1 << LANES_LOG2,
  localparam int STAGES    = 2 * LANES_LOG2 - 1,
  localparam int SEL_BITS  = LANES * STAGES
) (
  input  logic [LANES*WIDTH-1:0] data_i,
  input  logic [SEL_BITS-1:0]    sel_i,
  output logic [LANES*WIDTH-1:0] data_o
);

  logic [LANES*WIDTH-1:0] link [STAGES+1];

  assign link[0] = data_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    b2b_perm_stage #(
      .LANES (LANES),
      .WIDTH (WIDTH),
      .DIST  (b2b_perm_pkg::stage_dist(LANES_LOG2, s))
    ) u_stage (
      .lanes_i (link[s]),
      .sel_i   (sel_i[s*LANES +: LANES]),
      .lanes_o (link[s+1])
    );
  end

  assign data_o = link[STAGES];

endmodule

// File: rtl/b2b_perm_ctrl_store.sv
module b2b_perm_ctrl_store #(
  parameter int ENTRIES  = 8,
  parameter int SEL_BITS = 40,
  localparam int AW      = $clog2(ENTRIES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [SEL_BITS-1:0] wr_data_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [SEL_BITS-1:0] sel_o
);

  logic [SEL_BITS-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) mem_q[e] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  // registered read: same-edge write is not visible yet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_o <= '0;
    else         sel_o <= mem_q[rd_addr_i];
  end

endmodule

// File: rtl/b2b_perm_net.sv
module b2b_perm_net #(
  parameter int LANES_LOG2 = 3,
  parameter int WIDTH      = 8,
  parameter int ENTRIES    = 8,
  localparam int LANES     = 1 << LANES_LOG2,
  localparam int STAGES    = 2 * LANES_LOG2 - 1,
  localparam int SEL_BITS  = LANES * STAGES,
  localparam int AW        = $clog2(ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LANES*WIDTH-1:0] data_i,
  input  logic [AW-1:0]          perm_id_i,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [SEL_BITS-1:0]    wr_data_i,
  output logic [LANES*WIDTH-1:0] data_o
);

  logic [LANES*WIDTH-1:0] data_q;
  logic [SEL_BITS-1:0]    sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_i;
  end

  b2b_perm_ctrl_store #(
    .ENTRIES  (ENTRIES),
    .SEL_BITS (SEL_BITS)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (perm_id_i),
    .sel_o     (sel_q)
  );

  b2b_perm_fabric #(
    .LANES_LOG2 (LANES_LOG2),
    .WIDTH      (WIDTH)
  ) u_fabric (
    .data_i (data_q),
    .sel_i  (sel_q),
    .data_o (data_o)
  );

endmodule

// File: rtl/b2b_perm_net_chk.sv
module b2b_perm_net_chk #(
  parameter int DATA_BITS = 64,
  parameter int SEL_BITS  = 40,
  parameter int AW        = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [DATA_BITS-1:0] data_i,
  input logic [AW-1:0]        perm_id_i,
  input logic                 wr_en_i,
  input logic [AW-1:0]        wr_addr_i,
  input logic [SEL_BITS-1:0]  wr_data_i,
  input logic [DATA_BITS-1:0] data_o,
  input logic [DATA_BITS-1:0] data_q,
  input logic [SEL_BITS-1:0]  sel_q
);

  logic [1:0] warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  p_reset_out_r1: assert property (@(posedge clk_i)
    !rst_ni |-> data_o == '0);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && $stable(data_i) && $stable(perm_id_i) && !$past(wr_en_i))
    |=> $stable(data_o));

  p_identity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == '0) |-> data_o == data_q);

  p_write_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && $past(wr_en_i) && perm_id_i == $past(wr_addr_i))
    |=> sel_q == $past(wr_data_i, 2));

endmodule

bind b2b_perm_net b2b_perm_net_chk #(
  .DATA_BITS (LANES*WIDTH),
  .SEL_BITS  (SEL_BITS),
  .AW        (AW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_i    (data_i),
  .perm_id_i (perm_id_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .data_o    (data_o),
  .data_q    (data_q),
  .sel_q     (sel_q)
);

// File: tb/b2b_perm_net_test.sv
`timescale 1ns/1ps
module b2b_perm_net_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] data_i = '0;
  logic [1:0]  perm_id_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [11:0] wr_data_i = '0;
  logic [31:0] data_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk_i = ~clk_i;

  b2b_perm_net #(.LANES_LOG2(2), .WIDTH(8), .ENTRIES(4)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .perm_id_i(perm_id_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .data_o(data_o)
  );

  // src[j*2 +: 2] names the input lane that output lane j must carry
  function automatic logic [31:0] remap(input logic [31:0] d, input logic [7:0] src);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[j*8 +: 8] = d[int'(src[j*2 +: 2])*8 +: 8];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load(input logic [1:0] addr, input logic [11:0] pat);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = addr; wr_data_i = pat;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic run_case(input string tag, input logic [1:0] id,
                          input logic [31:0] d, input logic [7:0] src);
    @(negedge clk_i);
    data_i = d; perm_id_i = id;
    @(negedge clk_i);
    check(tag, data_o, remap(d, src));
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    data_i = 32'hdead_beef;
    @(negedge clk_i);
    check("R1 out in reset", data_o, 32'h0);
    rst_ni = 1'b1;
    #0.5;
    check("R1 out after release", data_o, 32'h0);
    // untouched entries come up as identity
    run_case("R1 R5 reset entry identity", 2'd3, 32'h4433_2211, {2'd3, 2'd2, 2'd1, 2'd0});
  endtask

  task automatic test_single_mux();
    // R3 R4: one select bit at a time shows partner and bit position
    load(2'd0, 12'h001);
    run_case("R3 R4 stage0 mux0", 2'd0, 32'hd4c3_b2a1, {2'd3, 2'd2, 2'd1, 2'd2});
    load(2'd0, 12'h020);
    run_case("R3 R4 stage1 mux1", 2'd0, 32'hd4c3_b2a1, {2'd3, 2'd2, 2'd0, 2'd0});
    load(2'd0, 12'h800);
    run_case("R3 R4 stage2 mux3", 2'd0, 32'hd4c3_b2a1, {2'd1, 2'd2, 2'd1, 2'd0});
  endtask

  task automatic test_mappings();
    load(2'd0, 12'hA35);
    load(2'd1, 12'hFFA);
    load(2'd2, 12'h00F);
    load(2'd3, 12'h030);
    run_case("R6 example a", 2'd0, 32'h0302_0100, {2'd2, 2'd0, 2'd3, 2'd1});
    run_case("R6 example b", 2'd0, 32'h7f5a_c3e1, {2'd2, 2'd0, 2'd3, 2'd1});
    run_case("R6 rotate 1",  2'd1, 32'h4433_2211, {2'd0, 2'd3, 2'd2, 2'd1});
    run_case("R6 rotate 2",  2'd2, 32'h4433_2211, {2'd1, 2'd0, 2'd3, 2'd2});
    run_case("R9 split frames", 2'd3, 32'h4433_2211, {2'd3, 2'd2, 2'd0, 2'd1});
  endtask

  task automatic test_latency();
    logic [31:0] held;
    @(negedge clk_i);
    data_i = 32'h1234_5678; perm_id_i = 2'd1;
    @(negedge clk_i);
    held = data_o;
    check("R2 one cycle", held, remap(32'h1234_5678, {2'd0, 2'd3, 2'd2, 2'd1}));
    data_i = 32'h0bad_f00d; perm_id_i = 2'd2;
    #1;
    check("R2 hold between edges", data_o, held);
    @(negedge clk_i);
    check("R2 next result", data_o, remap(32'h0bad_f00d, {2'd1, 2'd0, 2'd3, 2'd2}));
  endtask

  task automatic test_write_read();
    // same-edge write and read of entry 3: old split pattern first
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 2'd3; wr_data_i = 12'hA35;
    data_i = 32'h4433_2211; perm_id_i = 2'd3;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R7 same edge old", data_o, remap(32'h4433_2211, {2'd3, 2'd2, 2'd0, 2'd1}));
    @(negedge clk_i);
    check("R7 new contents", data_o, remap(32'h4433_2211, {2'd2, 2'd0, 2'd3, 2'd1}));
    run_case("R8 entry 1 kept", 2'd1, 32'h8877_6655, {2'd0, 2'd3, 2'd2, 2'd1});
    run_case("R8 entry 2 kept", 2'd2, 32'h8877_6655, {2'd1, 2'd0, 2'd3, 2'd2});
    load(2'd2, 12'h000);
    run_case("R5 zero entry", 2'd2, 32'h8877_6655, {2'd3, 2'd2, 2'd1, 2'd0});
  endtask

  initial begin
    #1;
    test_reset();
    test_single_mux();
    test_mappings();
    test_latency();
    test_write_read();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule